// File: doc/BRIEF.md
# Class-Prioritized Memory Request Queue with Isochronous Timeout Promotion

This block sits in front of a memory port and buffers requests that arrive from several network sources. A request names its source, a read/write flag and a payload (address and ID bits). The source index fixes the request's traffic class: low latency, isochronous or best effort. The queue issues at most one request per cycle on a valid/ready egress port. It always picks by strict class rank, and requests of equal rank leave in the order they arrived.

A request tagged low latency that turns out to be a write is stored as best effort. A sticky flag records that this happened. Each isochronous entry starts an age counter on the cycle it is written. Once the age reaches the programmed timeout, the entry jumps ahead of every other class and is issued next. If several entries have expired, the oldest of them goes first. A timeout of zero turns promotion off. An offered egress request stays frozen until the consumer accepts it. Ingress ready drops while all entries are occupied.

Top module: `tc_req_queue`

## Requirements
- R1: After reset the queue is empty: `out_valid` is 0, `in_ready` is 1 and `ll_write_seen` is 0.
- R2: A request's class comes from its source index through the `PORT_CLASS` parameter (default: source 0 low latency, sources 1 and 3 isochronous, source 2 best effort). It is reported on `out_class` as 0 = low latency, 1 = isochronous, 2 = best effort.
- R3: Among entries that are not promoted, a low-latency entry issues before any isochronous entry, and an isochronous entry issues before any best-effort entry.
- R4: Entries of the same class issue in the order they were accepted.
- R5: A write from a low-latency source is stored and issued as best effort (`out_class` = 2) and queued in arrival order with other best-effort traffic. Accepting such a write sets `ll_write_seen`, which stays 1 until reset.
- R6: An isochronous entry that has been held for at least `cfg_timeout` cycles (when `cfg_timeout` is nonzero) is issued ahead of every non-promoted entry, including low latency. Before that point it keeps its normal rank.
- R7: When several entries have expired, the one accepted earliest issues first.
- R8: With `cfg_timeout` = 0 no entry is ever promoted, however long it waits.
- R9: The queue holds `DEPTH` (8) entries. With all of them occupied, `in_ready` is 0 and a request offered on ingress is not stored.
- R10: While `out_valid` is 1 and `out_ready` is 0, the next cycle shows `out_valid` at 1 and the same `out_write`, `out_payload` and `out_class`, even if higher-ranked requests arrive or timers expire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_timeout | input | TMR_W (16) | Isochronous promotion threshold in cycles; 0 disables promotion |
| in_valid | input | 1 | Ingress request present |
| in_ready | output | 1 | Queue can accept a request |
| in_src | input | SRC_W (2) | Source index of the request |
| in_write | input | 1 | 1 = write, 0 = read |
| in_payload | input | PAY_W (8) | Address/ID payload |
| out_valid | output | 1 | Egress request present |
| out_ready | input | 1 | Downstream accepts the egress request |
| out_write | output | 1 | Read/write flag of the egress request |
| out_payload | output | PAY_W (8) | Payload of the egress request |
| out_class | output | 2 | Effective class of the egress request |
| ll_write_seen | output | 1 | Sticky: a low-latency-source write was downgraded |

## Verification
Some properties are checked on every cycle. A stalled egress request holds its contents until accepted. No issued write carries the low-latency class. The downgrade flag never clears on its own. Whenever an expired entry exists and the egress is not frozen, the chosen entry is an expired one. Ingress never writes into a full queue, and the entry count never exceeds its depth.

Other behaviour depends on history, so only the bench's scenarios show it. These are the complete issue order of mixed-class batches, arrival order within a class, and the difference between a short timeout, a long timeout and a zero timeout. The bench also shows that a request refused while the queue is full never appears on egress.

// File: rtl/tcq_pkg.sv
package tcq_pkg;

  // Effective traffic class of a stored request; lower value ranks higher.
  typedef enum logic [1:0] {
    TC_LOWLAT  = 2'd0,
    TC_ISOCH   = 2'd1,
    TC_BESTEFF = 2'd2
  } tclass_e;

endpackage

// File: rtl/tcq_ingress.sv
module tcq_ingress
  import tcq_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int SRC_W = 2,
  parameter logic [2*NUM_SRC-1:0] PORT_CLASS = '0
) (
  input  logic [SRC_W-1:0] src,
  input  logic             write,
  output tclass_e          cls,
  output logic             downgrade
);

  logic [1:0] raw_cls;

  always_comb begin
    raw_cls   = PORT_CLASS[{src, 1'b0} +: 2];
    downgrade = 1'b0;
    case (raw_cls)
      2'd0: begin
        // low-latency handling is for reads only
        if (write) begin
          cls       = TC_BESTEFF;
          downgrade = 1'b1;
        end else begin
          cls = TC_LOWLAT;
        end
      end
      2'd1:    cls = TC_ISOCH;
      default: cls = TC_BESTEFF;
    endcase
  end

endmodule

// File: rtl/tcq_store.sv
module tcq_store
  import tcq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PAY_W = 8,
  parameter int TMR_W = 16,
  parameter int CNT_W = 4,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  tclass_e          push_cls,
  input  logic             push_wr,
  input  logic [PAY_W-1:0] push_pay,
  input  logic             pop,
  input  logic [IDX_W-1:0] pop_idx,
  input  logic [TMR_W-1:0] tmo,
  output logic [CNT_W-1:0] count,
  output logic [DEPTH-1:0] ent_vld,
  output logic [DEPTH-1:0] ent_exp,
  output tclass_e          ent_cls [DEPTH],
  output logic             ent_wr  [DEPTH],
  output logic [PAY_W-1:0] ent_pay [DEPTH]
);

  // Index order is arrival order: slot 0 holds the oldest entry.
  tclass_e          cls_q [DEPTH], cls_d [DEPTH], sh_cls [DEPTH];
  logic             wr_q  [DEPTH], wr_d  [DEPTH], sh_wr  [DEPTH];
  logic [PAY_W-1:0] pay_q [DEPTH], pay_d [DEPTH], sh_pay [DEPTH];
  logic [TMR_W-1:0] age_q [DEPTH], age_d [DEPTH], sh_age [DEPTH];
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_mid;
  logic             data_en;

  // Collapse network: slots at or above the removed one take their upper neighbour.
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic take_up;
    assign take_up = pop && (IDX_W'(g) >= pop_idx);
    if (g < DEPTH - 1) begin : g_mid
      assign sh_cls[g] = take_up ? cls_q[g+1] : cls_q[g];
      assign sh_wr[g]  = take_up ? wr_q[g+1]  : wr_q[g];
      assign sh_pay[g] = take_up ? pay_q[g+1] : pay_q[g];
      assign sh_age[g] = take_up ? age_q[g+1] : age_q[g];
    end else begin : g_top
      assign sh_cls[g] = cls_q[g];
      assign sh_wr[g]  = wr_q[g];
      assign sh_pay[g] = pay_q[g];
      assign sh_age[g] = age_q[g];
    end
    assign ent_vld[g] = CNT_W'(g) < cnt_q;
    assign ent_exp[g] = ent_vld[g] && (cls_q[g] == TC_ISOCH) &&
                        (tmo != '0) && (age_q[g] >= tmo);
    assign ent_cls[g] = cls_q[g];
    assign ent_wr[g]  = wr_q[g];
    assign ent_pay[g] = pay_q[g];
  end

  always_comb begin
    cnt_mid = cnt_q - CNT_W'(pop);
    for (int i = 0; i < DEPTH; i++) begin
      cls_d[i] = sh_cls[i];
      wr_d[i]  = sh_wr[i];
      pay_d[i] = sh_pay[i];
      age_d[i] = ((sh_cls[i] == TC_ISOCH) && (sh_age[i] != '1)) ? sh_age[i] + 1'b1 : sh_age[i];
      if (push && (CNT_W'(i) == cnt_mid)) begin
        cls_d[i] = push_cls;
        wr_d[i]  = push_wr;
        pay_d[i] = push_pay;
        age_d[i] = '0;
      end
    end
    cnt_d   = cnt_mid + CNT_W'(push);
    data_en = push | pop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        cls_q[i] <= TC_BESTEFF;
        wr_q[i]  <= 1'b0;
        pay_q[i] <= '0;
        age_q[i] <= '0;
      end
    end else begin
      cnt_q <= cnt_d;
      for (int i = 0; i < DEPTH; i++) begin
        age_q[i] <= age_d[i];
        if (data_en) begin
          cls_q[i] <= cls_d[i];
          wr_q[i]  <= wr_d[i];
          pay_q[i] <= pay_d[i];
        end
      end
    end
  end

  assign count = cnt_q;

  // R9: storage is never written past its depth
  p_push_room_r9: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt_q < CNT_W'(DEPTH)));

  p_count_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

  p_pop_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> ent_vld[pop_idx]);

endmodule

// File: rtl/tcq_pick.sv
module tcq_pick
  import tcq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3
) (
  input  logic [DEPTH-1:0] vld,
  input  logic [DEPTH-1:0] expd,
  input  tclass_e          cls [DEPTH],
  output logic             hit,
  output logic [IDX_W-1:0] idx
);

  logic             f_exp, f_ll, f_iso;
  logic [IDX_W-1:0] i_exp, i_ll, i_iso, i_be;

  // Scan from the top so the lowest (oldest) matching slot wins in each group.
  always_comb begin
    f_exp = 1'b0; f_ll = 1'b0; f_iso = 1'b0;
    i_exp = '0;   i_ll = '0;   i_iso = '0;   i_be = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (vld[i]) begin
        if (expd[i]) begin
          f_exp = 1'b1;
          i_exp = IDX_W'(i);
        end
        if (cls[i] == TC_LOWLAT) begin
          f_ll = 1'b1;
          i_ll = IDX_W'(i);
        end
        if (cls[i] == TC_ISOCH) begin
          f_iso = 1'b1;
          i_iso = IDX_W'(i);
        end
        if (cls[i] == TC_BESTEFF) begin
          i_be = IDX_W'(i);
        end
      end
    end
    hit = |vld;
    if (f_exp)      idx = i_exp;
    else if (f_ll)  idx = i_ll;
    else if (f_iso) idx = i_iso;
    else            idx = i_be;
  end

endmodule

// File: rtl/tc_req_queue.sv
module tc_req_queue
  import tcq_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int DEPTH = 8,
  parameter int PAY_W = 8,
  parameter int TMR_W = 16,
  parameter logic [2*NUM_SRC-1:0] PORT_CLASS = 8'b01_10_01_00,
  localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TMR_W-1:0] cfg_timeout,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [SRC_W-1:0] in_src,
  input  logic             in_write,
  input  logic [PAY_W-1:0] in_payload,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_write,
  output logic [PAY_W-1:0] out_payload,
  output logic [1:0]       out_class,
  output logic             ll_write_seen
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  // Reset: asserted asynchronously, released on the second clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  tclass_e          in_cls;
  logic             in_dg;
  logic             push, pop;
  logic [CNT_W-1:0] count;
  logic [DEPTH-1:0] ent_vld, ent_exp;
  tclass_e          ent_cls [DEPTH];
  logic             ent_wr  [DEPTH];
  logic [PAY_W-1:0] ent_pay [DEPTH];
  logic             pick_hit;
  logic [IDX_W-1:0] pick_idx, sel_idx;
  logic             held_q, held_d;
  logic [IDX_W-1:0] held_idx_q, held_idx_d;
  logic             sticky_q, sticky_d;

  tcq_ingress #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W), .PORT_CLASS(PORT_CLASS)) u_ingress (
    .src(in_src), .write(in_write), .cls(in_cls), .downgrade(in_dg)
  );

  tcq_store #(.DEPTH(DEPTH), .PAY_W(PAY_W), .TMR_W(TMR_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_core_n),
    .push(push), .push_cls(in_cls), .push_wr(in_write), .push_pay(in_payload),
    .pop(pop), .pop_idx(sel_idx), .tmo(cfg_timeout),
    .count(count), .ent_vld(ent_vld), .ent_exp(ent_exp),
    .ent_cls(ent_cls), .ent_wr(ent_wr), .ent_pay(ent_pay)
  );

  tcq_pick #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_pick (
    .vld(ent_vld), .expd(ent_exp), .cls(ent_cls), .hit(pick_hit), .idx(pick_idx)
  );

  // Egress: a stalled offer freezes its slot; slots only move on acceptance.
  always_comb begin
    in_ready   = count < CNT_W'(DEPTH);
    push       = in_valid && in_ready;
    sel_idx    = held_q ? held_idx_q : pick_idx;
    out_valid  = held_q || pick_hit;
    pop        = out_valid && out_ready;
    held_d     = out_valid && !out_ready;
    held_idx_d = sel_idx;
    sticky_d   = sticky_q || (push && in_dg);
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      held_q     <= 1'b0;
      held_idx_q <= '0;
      sticky_q   <= 1'b0;
    end else begin
      held_q     <= held_d;
      held_idx_q <= held_idx_d;
      sticky_q   <= sticky_d;
    end
  end

  assign out_write     = ent_wr[sel_idx];
  assign out_payload   = ent_pay[sel_idx];
  assign out_class     = ent_cls[sel_idx];
  assign ll_write_seen = sticky_q;

  // R10: a stalled egress request does not change
  p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_core_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_payload) &&
                                   $stable(out_write) && $stable(out_class)));

  // R5: a write never leaves with the low-latency class
  p_no_ll_write_r5: assert property (@(posedge clk) disable iff (!rst_core_n)
    (out_valid && out_write) |-> (out_class != TC_LOWLAT));

  // R5: downgrade flag is sticky
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_core_n)
    ll_write_seen |=> ll_write_seen);

  // R6: when not frozen, an expired entry always wins selection
  p_promote_first_r6: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!held_q && (|ent_exp)) |-> ent_exp[sel_idx]);

endmodule

// File: tb/tc_req_queue_test.sv
`timescale 1ns/1ps
module tc_req_queue_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [15:0] cfg_timeout;
  logic       in_valid, in_ready, in_write;
  logic [1:0] in_src;
  logic [7:0] in_payload;
  logic       out_valid, out_ready, out_write;
  logic [7:0] out_payload;
  logic [1:0] out_class;
  logic       ll_write_seen;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  tc_req_queue uut (
    .clk(clk), .rst_n(rst_n), .cfg_timeout(cfg_timeout),
    .in_valid(in_valid), .in_ready(in_ready), .in_src(in_src),
    .in_write(in_write), .in_payload(in_payload),
    .out_valid(out_valid), .out_ready(out_ready), .out_write(out_write),
    .out_payload(out_payload), .out_class(out_class), .ll_write_seen(ll_write_seen)
  );

  // {source, write, payload}; loaded with egress stalled, timeout 0
  localparam logic [10:0] VEC [24] = '{
    {2'd2,1'b0,8'h10}, {2'd1,1'b0,8'h11}, {2'd0,1'b0,8'h12}, {2'd3,1'b1,8'h13},
    {2'd0,1'b0,8'h20}, {2'd2,1'b1,8'h21}, {2'd0,1'b1,8'h22}, {2'd1,1'b0,8'h23},
    {2'd3,1'b0,8'h30}, {2'd2,1'b0,8'h31}, {2'd2,1'b1,8'h32}, {2'd0,1'b0,8'h33},
    {2'd1,1'b1,8'h40}, {2'd1,1'b0,8'h41}, {2'd0,1'b0,8'h42}, {2'd0,1'b0,8'h43},
    {2'd2,1'b0,8'h50}, {2'd2,1'b1,8'h51}, {2'd3,1'b0,8'h52}, {2'd0,1'b1,8'h53},
    {2'd0,1'b1,8'h60}, {2'd3,1'b0,8'h61}, {2'd0,1'b0,8'h62}, {2'd2,1'b0,8'h63}
  };

  function automatic logic [1:0] exp_cls(input logic [1:0] s, input logic w);
    case (s)
      2'd0:    exp_cls = w ? 2'd2 : 2'd0;
      2'd2:    exp_cls = 2'd2;
      default: exp_cls = 2'd1;
    endcase
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    in_src = '0; in_write = 1'b0; in_payload = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic push(input logic [1:0] s, input logic w, input logic [7:0] p);
    @(negedge clk);
    in_valid = 1'b1; in_src = s; in_write = w; in_payload = p;
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic pop_check(input logic [7:0] ep, input logic [1:0] ec, input string tag);
    @(negedge clk);
    out_ready = 1'b1; #1;
    chk(out_valid === 1'b1, {tag, " valid"}, out_valid, 1);
    chk(out_payload === ep, {tag, " payload"}, out_payload, ep);
    chk(out_class === ec, {tag, " class"}, out_class, ec);
    @(posedge clk); #1;
    out_ready = 1'b0;
  endtask

  task automatic expect_empty(input string tag);
    @(negedge clk); #1;
    chk(out_valid === 1'b0, tag, out_valid, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] m_pay [4];
    logic [1:0] m_cls [4];
    bit         m_live [4];

    cfg_timeout = 16'd0;
    do_reset();

    // R1: reset state
    #1;
    chk(out_valid === 1'b0, "R1 out_valid", out_valid, 0);
    chk(in_ready === 1'b1, "R1 in_ready", in_ready, 1);
    chk(ll_write_seen === 1'b0, "R1 ll_write_seen", ll_write_seen, 0);

    // Table: R2 R3 R4 R8 (timeout 0), R10 lock on the first loaded entry
    for (int v = 0; v < 6; v++) begin
      for (int k = 0; k < 4; k++) begin
        logic [10:0] e;
        e = VEC[v*4 + k];
        push(e[10:9], e[8], e[7:0]);
        m_pay[k] = e[7:0];
        m_cls[k] = exp_cls(e[10:9], e[8]);
        m_live[k] = 1'b1;
      end
      repeat (4) @(negedge clk);
      #1;
      chk(out_payload === m_pay[0], "R10 stalled head", out_payload, m_pay[0]);
      for (int n = 0; n < 4; n++) begin
        int best;
        best = -1;
        if (n == 0) best = 0;
        else begin
          for (int k = 0; k < 4; k++)
            if (m_live[k] && (best < 0 || m_cls[k] < m_cls[best])) best = k;
        end
        pop_check(m_pay[best], m_cls[best], "R2 R3 R4 R8 table");
        m_live[best] = 1'b0;
      end
      expect_empty("R4 table drained");
    end

    // R5: low-latency write downgrade and sticky flag
    do_reset();
    #1;
    chk(ll_write_seen === 1'b0, "R5 flag clear", ll_write_seen, 0);
    push(2'd2, 1'b0, 8'h50);
    push(2'd0, 1'b1, 8'h51);
    push(2'd0, 1'b0, 8'h52);
    #1;
    chk(ll_write_seen === 1'b1, "R5 flag set", ll_write_seen, 1);
    chk(out_payload === 8'h50, "R10 head kept after LL arrival", out_payload, 8'h50);
    pop_check(8'h50, 2'd2, "R5");
    pop_check(8'h52, 2'd0, "R5");
    pop_check(8'h51, 2'd2, "R5 downgraded");
    #1;
    chk(ll_write_seen === 1'b1, "R5 flag sticky", ll_write_seen, 1);

    // R6: short timeout promotes isochronous over low latency
    cfg_timeout = 16'd5;
    push(2'd2, 1'b0, 8'h80);
    push(2'd1, 1'b0, 8'h81);
    push(2'd0, 1'b0, 8'h82);
    repeat (12) @(negedge clk);
    pop_check(8'h80, 2'd2, "R6");
    pop_check(8'h81, 2'd1, "R6 promoted");
    pop_check(8'h82, 2'd0, "R6");

    // R6: before its timeout an isochronous entry keeps normal rank
    cfg_timeout = 16'd200;
    push(2'd2, 1'b0, 8'h90);
    push(2'd1, 1'b0, 8'h91);
    push(2'd0, 1'b0, 8'h92);
    repeat (12) @(negedge clk);
    pop_check(8'h90, 2'd2, "R6 early");
    pop_check(8'h92, 2'd0, "R6 early");
    pop_check(8'h91, 2'd1, "R6 early");

    // R8: zero timeout, long wait, no promotion
    cfg_timeout = 16'd0;
    push(2'd2, 1'b0, 8'h94);
    push(2'd3, 1'b0, 8'h95);
    push(2'd0, 1'b0, 8'h96);
    repeat (40) @(negedge clk);
    pop_check(8'h94, 2'd2, "R8");
    pop_check(8'h96, 2'd0, "R8 no promotion");
    pop_check(8'h95, 2'd1, "R8");

    // R7: several expired entries leave oldest first
    cfg_timeout = 16'd3;
    push(2'd2, 1'b0, 8'hA0);
    push(2'd3, 1'b0, 8'hA1);
    push(2'd1, 1'b1, 8'hA2);
    push(2'd0, 1'b0, 8'hA3);
    repeat (12) @(negedge clk);
    pop_check(8'hA0, 2'd2, "R7");
    pop_check(8'hA1, 2'd1, "R7 oldest expired");
    pop_check(8'hA2, 2'd1, "R7 next expired");
    pop_check(8'hA3, 2'd0, "R7");
    expect_empty("R7 drained");

    // R9: full queue refuses ingress
    cfg_timeout = 16'd0;
    for (int k = 0; k < 8; k++) push(2'd2, 1'b0, 8'h70 + 8'(k));
    #1;
    chk(in_ready === 1'b0, "R9 in_ready full", in_ready, 0);
    push(2'd0, 1'b0, 8'h7F);
    #1;
    chk(in_ready === 1'b0, "R9 still full", in_ready, 0);
    for (int k = 0; k < 8; k++) pop_check(8'h70 + 8'(k), 2'd2, "R9 drain");
    expect_empty("R9 refused request absent");
    #1;
    chk(in_ready === 1'b1, "R9 ready after drain", in_ready, 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule